// File: doc/BRIEF.md
# Mode-Aware Bidirectional GPIO Port

This block is an eight-pin general-purpose I/O port. It holds a write-only direction register and a readable data register, both reached through a small synchronous register bus. The block drives separate pin-data and per-pin output-enable vectors, so the tri-state pads stay outside it. Each pin input passes through a two-flop synchronizer before it reaches the read path.

The port works in one of two operating modes. In single-chip mode, a pin is a driven output when its direction bit is 1 and an input when the bit is 0. In extended mode, the pins belong to an external data-bus path. That path supplies the pin data and one drive-enable, and the port registers then affect only what a port read returns.

A four-state mode machine follows the `ext_mode` input. Its states are MODE_SINGLE, MODE_TO_EXT, MODE_EXT and MODE_TO_SINGLE, and it has these transitions:

- MODE_SINGLE goes to MODE_TO_EXT when `ext_mode` is 1.
- MODE_TO_EXT goes to MODE_EXT when `ext_mode` is 1, and to MODE_TO_SINGLE when it is 0.
- MODE_EXT goes to MODE_TO_SINGLE when `ext_mode` is 0.
- MODE_TO_SINGLE goes to MODE_SINGLE when `ext_mode` is 0, and to MODE_TO_EXT when it is 1.
- In every other case the state holds.

The two transit states each last at least one cycle. During a transit state no pin is driven, so the register path and the bus path are never enabled together.

Top module: `gpio_port`

## Requirements
- R1: After reset, the direction register and the data register are 0, the mode state is MODE_SINGLE, both synchronizer stages are 0, and `pin_oe` and `pin_out` are 0.
- R2: In MODE_SINGLE, `pin_oe[n]` equals direction bit n. `pin_out[n]` equals data bit n where direction bit n is 1, and is 0 where it is 0.
- R3: When `rd_en` is 1, `reg_addr` is 1 (data) and the state is MODE_SINGLE or MODE_TO_SINGLE, `rd_data[n]` is data bit n where direction bit n is 1. Where direction bit n is 0, it is the synchronized level of pin n.
- R4: When `rd_en` is 1, `reg_addr` is 1 and the state is MODE_TO_EXT or MODE_EXT, `rd_data[n]` is data bit n where direction bit n is 1, and 1 where direction bit n is 0.
- R5: When `rd_en` is 1 and `reg_addr` is 0 (direction), `rd_data` is 8'hFF. When `rd_en` is 0, `rd_data` is 0.
- R6: In MODE_EXT, every bit of `pin_oe` equals `bus_oe`, and `pin_out` equals `bus_wdata`, whatever the registers hold.
- R7: In MODE_TO_EXT and MODE_TO_SINGLE, `pin_oe` and `pin_out` are 0. The state follows the transitions listed above, one step per clock, so each change of mode passes through one transit state.
- R8: A change on `pin_in` reaches `rd_data` on the second rising edge after it is applied, and not on the first.
- R9: With `wr_en` at 1, a rising edge loads `wr_data` into the register that `reg_addr` selects (0 is direction, 1 is data). A read in the same cycle as a write returns the value from before the write.
- R10: Register writes take effect in every mode state. They reach the pins as soon as the state is MODE_SINGLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ext_mode | input | 1 | 1 requests extended (bus) mode, 0 requests single-chip mode |
| reg_addr | input | 1 | Register select: 0 direction, 1 data |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 8 | Register write data |
| rd_en | input | 1 | Register read strobe |
| rd_data | output | 8 | Combinational read data |
| pin_in | input | 8 | Pin levels from the pads |
| bus_oe | input | 1 | Drive enable from the external bus path |
| bus_wdata | input | 8 | Pin data from the external bus path |
| pin_out | output | 8 | Pin data to the pads |
| pin_oe | output | 8 | Per-pin output enable to the pads |

## Verification
Two things can fall in the same cycle. A register write can coincide with a read of the same register, and a mode change can coincide with a register write or a pin change. The bench provokes both: it issues directed write-plus-read cycles on the data address and holds a pin toggle against a mode flip, then runs long stretches where `ext_mode`, the strobes and the pins move together at random. A behavioural model keeps the registers, the two synchronizer stages and the mode state, and it is compared with all three outputs every cycle. A read that overlaps a write must return the older value. Every mode flip must show a cycle with no pin driven, whatever writes arrive in that cycle.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    typedef enum logic [1:0] {
        MODE_SINGLE    = 2'd0,
        MODE_TO_EXT    = 2'd1,
        MODE_EXT       = 2'd2,
        MODE_TO_SINGLE = 2'd3
    } port_mode_e;

    localparam logic ADDR_DIR  = 1'b0;
    localparam logic ADDR_DATA = 1'b1;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[0] <= '0;
                    else        stage_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) stage_q[s] <= '0;
                    else        stage_q[s] <= stage_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             reg_addr,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] dir_q,
    output logic [WIDTH-1:0] data_q
);
    import gpio_port_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q  <= '0;
            data_q <= '0;
        end else if (wr_en) begin
            if (reg_addr == ADDR_DIR) dir_q  <= wr_data;
            else                      data_q <= wr_data;
        end
    end
endmodule

// File: rtl/gpio_mode_fsm.sv
module gpio_mode_fsm (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      ext_mode,
    output gpio_port_pkg::port_mode_e state,
    output logic                      drive_regs,
    output logic                      drive_bus,
    output logic                      ext_view
);
    import gpio_port_pkg::*;

    port_mode_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            MODE_SINGLE:    if (ext_mode) state_d = MODE_TO_EXT;
            MODE_TO_EXT:    state_d = ext_mode ? MODE_EXT : MODE_TO_SINGLE;
            MODE_EXT:       if (!ext_mode) state_d = MODE_TO_SINGLE;
            MODE_TO_SINGLE: state_d = ext_mode ? MODE_TO_EXT : MODE_SINGLE;
            default:        state_d = MODE_SINGLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= MODE_SINGLE;
        else        state_q <= state_d;
    end

    always_comb begin
        drive_regs = 1'b0;
        drive_bus  = 1'b0;
        ext_view   = 1'b0;
        unique case (state_q)
            MODE_SINGLE:    drive_regs = 1'b1;
            MODE_TO_EXT:    ext_view   = 1'b1;
            MODE_EXT: begin
                drive_bus = 1'b1;
                ext_view  = 1'b1;
            end
            MODE_TO_SINGLE: ext_view   = 1'b0;
            default:        drive_regs = 1'b0;
        endcase
    end

    assign state = state_q;
endmodule

// File: rtl/gpio_port.sv
module gpio_port #(
    parameter int WIDTH       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_mode,
    input  logic             reg_addr,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    input  logic [WIDTH-1:0] pin_in,
    input  logic             bus_oe,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_oe
);
    import gpio_port_pkg::*;

    logic [WIDTH-1:0] dir_q, data_q, pin_sync, port_view;
    port_mode_e       mode_state;
    logic             drive_regs, drive_bus, ext_view;

    gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(pin_in), .sync_out(pin_sync)
    );

    gpio_regs #(.WIDTH(WIDTH)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .reg_addr(reg_addr),
        .wr_data(wr_data), .dir_q(dir_q), .data_q(data_q)
    );

    gpio_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .state(mode_state),
        .drive_regs(drive_regs), .drive_bus(drive_bus), .ext_view(ext_view)
    );

    generate
        for (genvar b = 0; b < WIDTH; b++) begin : g_bit
            assign port_view[b] = dir_q[b] ? data_q[b]
                                           : (ext_view ? 1'b1 : pin_sync[b]);
        end
    endgenerate

    always_comb begin
        if (!rd_en)                   rd_data = '0;
        else if (reg_addr == ADDR_DIR) rd_data = {WIDTH{1'b1}};
        else                          rd_data = port_view;
    end

    always_comb begin
        if (drive_bus) begin
            pin_oe  = {WIDTH{bus_oe}};
            pin_out = bus_wdata;
        end else if (drive_regs) begin
            pin_oe  = dir_q;
            pin_out = data_q & dir_q;
        end else begin
            pin_oe  = '0;
            pin_out = '0;
        end
    end
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
    parameter int WIDTH = 8
) (
    input logic                      clk,
    input logic                      rst_n,
    input logic                      ext_mode,
    input logic                      reg_addr,
    input logic                      rd_en,
    input logic [WIDTH-1:0]          rd_data,
    input logic [WIDTH-1:0]          pin_in,
    input logic                      bus_oe,
    input logic [WIDTH-1:0]          bus_wdata,
    input logic [WIDTH-1:0]          pin_out,
    input logic [WIDTH-1:0]          pin_oe,
    input logic [WIDTH-1:0]          dir_q,
    input gpio_port_pkg::port_mode_e mode_state
);
    import gpio_port_pkg::*;

    logic [1:0] since_rst;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              since_rst <= 2'd0;
        else if (since_rst != 3) since_rst <= since_rst + 2'd1;
    end

    // R7
    enter_ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ext_mode) |=> (pin_oe == '0 && pin_out == '0));

    // R7
    leave_ext_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_mode) |=> (pin_oe == '0 && pin_out == '0));

    // R5
    dir_read_ones_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && reg_addr == ADDR_DIR) |-> rd_data == {WIDTH{1'b1}});

    // R2
    single_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == MODE_SINGLE) |-> pin_oe == dir_q);

    // R6
    ext_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_state == MODE_EXT) |-> (pin_oe == {WIDTH{bus_oe}} && pin_out == bus_wdata));

    // R8
    pin_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst == 3 && rd_en && reg_addr == ADDR_DATA && dir_q == '0
         && mode_state == MODE_SINGLE && $stable(dir_q))
        |-> rd_data == $past(pin_in, 2));
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .reg_addr(reg_addr),
    .rd_en(rd_en), .rd_data(rd_data), .pin_in(pin_in), .bus_oe(bus_oe),
    .bus_wdata(bus_wdata), .pin_out(pin_out), .pin_oe(pin_oe),
    .dir_q(dir_q), .mode_state(mode_state)
);

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_mode = 1'b0, reg_addr = 1'b0, wr_en = 1'b0, rd_en = 1'b0, bus_oe = 1'b0;
    logic [7:0] wr_data = 8'h00, pin_in = 8'h00, bus_wdata = 8'h00;
    logic [7:0] rd_data, pin_out, pin_oe;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // reference model state: 0 single, 1 to-ext, 2 ext, 3 to-single
    int         m_st;
    logic [7:0] m_dir, m_dat, m_s1, m_s2;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port u_gpio_port (
        .clk(clk), .rst_n(rst_n), .ext_mode(ext_mode), .reg_addr(reg_addr),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .pin_in(pin_in), .bus_oe(bus_oe), .bus_wdata(bus_wdata),
        .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st <= 0; m_dir <= 8'h00; m_dat <= 8'h00; m_s1 <= 8'h00; m_s2 <= 8'h00;
        end else begin
            m_s1 <= pin_in;
            m_s2 <= m_s1;
            if (wr_en && reg_addr) m_dat <= wr_data;
            if (wr_en && !reg_addr) m_dir <= wr_data;
            case (m_st)
                0: m_st <= ext_mode ? 1 : 0;
                1: m_st <= ext_mode ? 2 : 3;
                2: m_st <= ext_mode ? 2 : 3;
                default: m_st <= ext_mode ? 1 : 0;
            endcase
        end
    end

    task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic compare();
        logic [7:0] e_rd, e_oe, e_out;
        string rtag, ptag;
        bit ext_v;
        ext_v = (m_st == 1 || m_st == 2);
        if (!rd_en) begin
            e_rd = 8'h00; rtag = "R5";
        end else if (!reg_addr) begin
            e_rd = 8'hFF; rtag = "R5";
        end else begin
            for (int i = 0; i < 8; i++)
                e_rd[i] = m_dir[i] ? m_dat[i] : (ext_v ? 1'b1 : m_s2[i]);
            rtag = ext_v ? "R4" : "R3";
        end
        if (m_st == 0) begin
            e_oe = m_dir; e_out = m_dat & m_dir; ptag = "R2";
        end else if (m_st == 2) begin
            e_oe = {8{bus_oe}}; e_out = bus_wdata; ptag = "R6";
        end else begin
            e_oe = 8'h00; e_out = 8'h00; ptag = "R7";
        end
        check(rtag, "rd_data", rd_data, e_rd);
        check(ptag, "pin_oe", pin_oe, e_oe);
        check(ptag, "pin_out", pin_out, e_out);
    endtask

    task automatic cyc(input logic em, input logic ad, input logic we, input logic [7:0] wd,
                       input logic re, input logic [7:0] pin, input logic boe, input logic [7:0] bwd);
        @(negedge clk);
        ext_mode = em; reg_addr = ad; wr_en = we; wr_data = wd;
        rd_en = re; pin_in = pin; bus_oe = boe; bus_wdata = bwd;
        #1;
        compare();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++; total++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        rd_en = 1'b1; reg_addr = 1'b1;
        #1;
        // R1: reset state seen at the ports
        check("R1", "pin_oe", pin_oe, 8'h00);
        check("R1", "pin_out", pin_out, 8'h00);
        check("R1", "rd_data", rd_data, 8'h00);

        // R9 R2: write direction then data, with reads in the same cycle
        cyc(0, 0, 1, 8'h0F, 1, 8'hA0, 0, 8'h00);
        cyc(0, 1, 1, 8'h35, 1, 8'hA0, 0, 8'h00);   // R9 read returns old data
        cyc(0, 1, 0, 8'h00, 1, 8'hA0, 0, 8'h00);
        // R8: pin toggles, read after one and two edges
        cyc(0, 1, 0, 8'h00, 1, 8'h50, 0, 8'h00);
        cyc(0, 1, 0, 8'h00, 1, 8'h50, 0, 8'h00);
        cyc(0, 1, 0, 8'h00, 1, 8'h50, 0, 8'h00);
        // R7 R4 R6: go to extended, writes during handover (R10)
        cyc(1, 1, 1, 8'hC3, 1, 8'hFF, 1, 8'h96);
        cyc(1, 0, 1, 8'hF0, 1, 8'h00, 1, 8'h96);
        cyc(1, 1, 0, 8'h00, 1, 8'h00, 0, 8'h69);
        cyc(1, 1, 0, 8'h00, 1, 8'h00, 1, 8'h69);
        // R7: bounce back during transit
        cyc(0, 1, 0, 8'h00, 1, 8'h12, 1, 8'h00);
        cyc(1, 1, 0, 8'h00, 1, 8'h12, 1, 8'h00);
        cyc(0, 1, 0, 8'h00, 1, 8'h12, 1, 8'h00);
        cyc(0, 1, 0, 8'h00, 1, 8'h12, 1, 8'h00);
        cyc(0, 1, 0, 8'h00, 0, 8'h12, 1, 8'h00);   // R5 rd_en low

        // mixed random traffic, mode flips coinciding with writes and pin changes
        for (int n = 0; n < 3000; n++) begin
            logic em;
            em = ($urandom % 12 == 0) ? ~ext_mode : ext_mode;
            cyc(em, 1'($urandom), 1'($urandom % 3 == 0), 8'($urandom), 1'($urandom % 4 != 0),
                8'($urandom), 1'($urandom), 8'($urandom));
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule